// File: doc/BRIEF.md
# ADC Output Data Formatter

This block takes each sample word from a converter core, together with its overflow bit, and shapes the pair for the output pads. A normal sample goes through a fixed chain of stages, each with its own enable. First comes the choice between offset binary and two's complement. Next comes a randomizer that scrambles the upper data bits using the least significant bit. Last comes an inversion of the odd-numbered data bits, which reduces switching currents on the board. The result is captured in one output register whenever the sample strobe is high.

For board-level interface testing, a test-pattern enable replaces the formatted word with one of four fixed patterns. Two of these patterns alternate from one sample strobe to the next. A small state machine tracks the pattern phase. Its states are PH_OFF (no pattern is selected), PH_FIRST (the next strobed sample takes the first pattern) and PH_SECOND (the next strobed sample takes the second pattern). It has four transitions. The *enter* transition goes from PH_OFF to a phase. The *toggle* transition flips between PH_FIRST and PH_SECOND on a strobe. The *restart* transition returns to the first phase when the pattern selection changes. The *leave* transition goes back to PH_OFF when patterns are switched off.

An output-disable bit drops the enables for the data bus and for the clock output. The pad ring uses these enables to put all outputs, including the overflow bit, into high impedance.

Top module: `adc_out_fmt`

## Requirements
- R1: While reset is asserted, `out_word` is all zeros and both `out_word_oe` and `clkout_oe` are 0.
- R2: `out_word` loads on a rising clock edge where `smp_vld` is 1, so the latency is one cycle. On edges where `smp_vld` is 0, `out_word` holds its value.
- R3: With no pattern active, `out_word[14]` equals the overflow input. When `cfg_twos` is 0, the data bits pass through unchanged. When `cfg_twos` is 1, only D13 is inverted.
- R4: When `cfg_rand` is 1, each of D13..D1 is XORed with D0. D0 and the overflow bit stay unchanged.
- R5: When `cfg_altpol` is 1, data bits 1, 3, 5, 7, 9, 11 and 13 are inverted. The even bits and the overflow bit stay unchanged.
- R6: The randomizer and the odd-bit inversion can be enabled together. The randomizer is applied first, on the word after two's-complement conversion, and the inversion is applied to its result.
- R7: When `cfg_tp_en` is 1, the pattern code in `cfg_tp_sel` selects the output. Code 0 gives all ones (15'h7FFF) and code 1 gives all zeros, regardless of the data input, the overflow input and every formatting enable.
- R8: Code 2 gives alternating words. All ones goes out on the first strobed sample after a restart, and the output then flips between all ones and all zeros on each strobe. Cycles without a strobe do not advance the phase.
- R9: Code 3 gives a checkerboard that covers the overflow bit and D13..D0. The word is 15'h5555 (101010101010101) on the first phase and 15'h2AAA (010101010101010) on the second, and it flips on each strobe.
- R10: The phase restarts at the first pattern whenever `cfg_tp_en` rises or `cfg_tp_sel` changes while patterns are enabled.
- R11: On every clock edge after reset, `out_word_oe` and `clkout_oe` both become the inverse of `cfg_out_dis`, independent of `smp_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 14 | Offset-binary sample word |
| smp_ovf | input | 1 | Overflow flag for the sample |
| cfg_twos | input | 1 | Two's-complement output format |
| cfg_rand | input | 1 | Randomizer enable |
| cfg_altpol | input | 1 | Odd-bit inversion enable |
| cfg_tp_en | input | 1 | Test-pattern enable |
| cfg_tp_sel | input | 2 | Pattern code: 0 ones, 1 zeros, 2 alternating, 3 checkerboard |
| cfg_out_dis | input | 1 | Output disable |
| out_word | output | 15 | Overflow bit (bit 14) followed by D13..D0 |
| out_word_oe | output | 1 | Drive enable for the data bus and overflow pads |
| clkout_oe | output | 1 | Drive enable for the clock-output pad |

## Verification
A wrong phase state shows on the very next strobed sample in alternating or checkerboard mode. It appears as a repeated word, or as a start on the second pattern after a selection change. A stage applied in the wrong order or on the wrong bits shows in the word registered one cycle after the strobe. The clearest cases are inputs with D0 set and the randomizer and inversion both on, where the order of the stages changes the odd bits. A fault in the enable path appears one edge after the disable bit changes, even when no strobe is present.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        TP_ONES  = 2'd0,
        TP_ZEROS = 2'd1,
        TP_ALT   = 2'd2,
        TP_CHECK = 2'd3
    } tp_sel_e;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

endpackage

// File: rtl/adc_fmt_chain.sv
module adc_fmt_chain #(
    parameter int DATA_W = 14
) (
    input  logic [DATA_W-1:0] din,
    input  logic              twos_en,
    input  logic              rand_en,
    input  logic              altpol_en,
    output logic [DATA_W-1:0] dout
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] odd_mask;
    logic [DATA_W-1:0] s_twos;
    logic [DATA_W-1:0] s_rand;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_mask
            assign odd_mask[gi] = (gi % 2) == 1;
        end
    endgenerate

    always_comb begin
        s_twos      = din;
        s_twos[MSB] = din[MSB] ^ twos_en;
    end

    always_comb begin
        s_rand = s_twos;
        if (rand_en) begin
            s_rand[MSB:1] = s_twos[MSB:1] ^ {(DATA_W-1){s_twos[0]}};
        end
    end

    always_comb begin
        dout = altpol_en ? (s_rand ^ odd_mask) : s_rand;
    end

endmodule

// File: rtl/adc_fmt_phase.sv
module adc_fmt_phase
    import adc_fmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tp_en,
    input  tp_sel_e tp_sel,
    input  logic    smp_vld,
    output logic    phase_now
);
    phase_e  state_q;
    phase_e  state_d;
    tp_sel_e sel_q;
    logic    restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            sel_q   <= TP_ONES;
        end else begin
            state_q <= state_d;
            sel_q   <= tp_sel;
        end
    end

    always_comb begin
        restart   = tp_en && ((state_q == PH_OFF) || (tp_sel != sel_q));
        phase_now = !restart && (state_q == PH_SECOND);
        state_d   = state_q;
        unique case (state_q)
            PH_OFF: begin
                if (tp_en) begin
                    state_d = smp_vld ? PH_SECOND : PH_FIRST;
                end
            end
            PH_FIRST, PH_SECOND: begin
                if (!tp_en) begin
                    state_d = PH_OFF;
                end else if (smp_vld) begin
                    state_d = phase_now ? PH_FIRST : PH_SECOND;
                end else begin
                    state_d = phase_now ? PH_SECOND : PH_FIRST;
                end
            end
            default: state_d = PH_OFF;
        endcase
    end

endmodule

// File: rtl/adc_fmt_patgen.sv
module adc_fmt_patgen
    import adc_fmt_pkg::*;
#(
    parameter int WORD_W = 15
) (
    input  tp_sel_e           tp_sel,
    input  logic              phase,
    output logic [WORD_W-1:0] pat
);
    logic [WORD_W-1:0] chk_a;

    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_chk
            assign chk_a[gi] = ((WORD_W - 1 - gi) % 2) == 0;
        end
    endgenerate

    always_comb begin
        unique case (tp_sel)
            TP_ONES:  pat = '1;
            TP_ZEROS: pat = '0;
            TP_ALT:   pat = phase ? '0 : '1;
            TP_CHECK: pat = phase ? ~chk_a : chk_a;
            default:  pat = '0;
        endcase
    end

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_ovf,
    input  logic              cfg_twos,
    input  logic              cfg_rand,
    input  logic              cfg_altpol,
    input  logic              cfg_tp_en,
    input  logic [1:0]        cfg_tp_sel,
    input  logic              cfg_out_dis,
    output logic [DATA_W:0]   out_word,
    output logic              out_word_oe,
    output logic              clkout_oe
);
    localparam int WORD_W = DATA_W + 1;

    tp_sel_e           sel;
    logic              phase;
    logic [DATA_W-1:0] fmt_data;
    logic [WORD_W-1:0] pat;
    logic [WORD_W-1:0] word_d;

    assign sel = tp_sel_e'(cfg_tp_sel);

    adc_fmt_chain #(.DATA_W(DATA_W)) u_chain (
        .din       (smp_data),
        .twos_en   (cfg_twos),
        .rand_en   (cfg_rand),
        .altpol_en (cfg_altpol),
        .dout      (fmt_data)
    );

    adc_fmt_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tp_en     (cfg_tp_en),
        .tp_sel    (sel),
        .smp_vld   (smp_vld),
        .phase_now (phase)
    );

    adc_fmt_patgen #(.WORD_W(WORD_W)) u_pat (
        .tp_sel (sel),
        .phase  (phase),
        .pat    (pat)
    );

    always_comb begin
        word_d = cfg_tp_en ? pat : {smp_ovf, fmt_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word    <= '0;
            out_word_oe <= 1'b0;
            clkout_oe   <= 1'b0;
        end else begin
            out_word_oe <= !cfg_out_dis;
            clkout_oe   <= !cfg_out_dis;
            if (smp_vld) begin
                out_word <= word_d;
            end
        end
    end

endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [DATA_W-1:0] smp_data,
    input logic              smp_ovf,
    input logic              cfg_tp_en,
    input logic [1:0]        cfg_tp_sel,
    input logic              cfg_out_dis,
    input logic [DATA_W:0]   out_word,
    input logic              out_word_oe,
    input logic              clkout_oe
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(out_word));

    p_ovf_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !cfg_tp_en) |=> out_word[DATA_W] == $past(smp_ovf));

    p_d0_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !cfg_tp_en) |=> out_word[0] == $past(smp_data[0]));

    p_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_tp_en && cfg_tp_sel == 2'd0) |=> &out_word);

    p_zeros_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_tp_en && cfg_tp_sel == 2'd1) |=> out_word == '0);

    p_oe_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> out_word_oe == !$past(cfg_out_dis));

    p_clk_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> clkout_oe == out_word_oe);

endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld     (smp_vld),
    .smp_data    (smp_data),
    .smp_ovf     (smp_ovf),
    .cfg_tp_en   (cfg_tp_en),
    .cfg_tp_sel  (cfg_tp_sel),
    .cfg_out_dis (cfg_out_dis),
    .out_word    (out_word),
    .out_word_oe (out_word_oe),
    .clkout_oe   (clkout_oe)
);

// File: tb/tb_adc_out_fmt.sv
module tb_adc_out_fmt;
    localparam int CLK_P = 10;
    localparam int DW    = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          smp_ovf = 1'b0;
    logic          cfg_twos = 1'b0;
    logic          cfg_rand = 1'b0;
    logic          cfg_altpol = 1'b0;
    logic          cfg_tp_en = 1'b0;
    logic [1:0]    cfg_tp_sel = 2'd0;
    logic          cfg_out_dis = 1'b0;
    logic [DW:0]   out_word;
    logic          out_word_oe;
    logic          clkout_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW:0] exp_q[$];
    string       tag_q[$];
    logic [DW:0] last_exp = '0;

    logic       m_prev_en = 1'b0;
    logic [1:0] m_prev_sel = 2'd0;
    logic       m_phase = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    adc_out_fmt dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .smp_ovf(smp_ovf), .cfg_twos(cfg_twos), .cfg_rand(cfg_rand),
        .cfg_altpol(cfg_altpol), .cfg_tp_en(cfg_tp_en), .cfg_tp_sel(cfg_tp_sel),
        .cfg_out_dis(cfg_out_dis), .out_word(out_word), .out_word_oe(out_word_oe),
        .clkout_oe(clkout_oe)
    );

    function automatic logic [DW:0] model(input logic [DW-1:0] d, input logic ov,
                                          input logic ph);
        logic [DW-1:0] v;
        if (cfg_tp_en) begin
            case (cfg_tp_sel)
                2'd0: return 15'h7FFF;
                2'd1: return 15'h0000;
                2'd2: return ph ? 15'h0000 : 15'h7FFF;
                default: return ph ? 15'h2AAA : 15'h5555;
            endcase
        end
        v = d;
        if (cfg_twos) v[DW-1] = ~v[DW-1];
        if (cfg_rand) for (int i = 1; i < DW; i++) v[i] = v[i] ^ v[0];
        if (cfg_altpol) for (int i = 1; i < DW; i += 2) v[i] = ~v[i];
        return {ov, v};
    endfunction

    task automatic check(input logic [DW:0] act, input logic [DW:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: sets inputs at a falling edge, updates the pattern-phase model,
    // pushes the expected word for strobed samples, then waits one cycle.
    task automatic step(input logic vld, input logic [DW-1:0] d, input logic ov,
                        input string tag);
        logic restart;
        logic ph;
        smp_vld  = vld;
        smp_data = d;
        smp_ovf  = ov;
        restart = cfg_tp_en && (!m_prev_en || cfg_tp_sel != m_prev_sel);
        ph = restart ? 1'b0 : m_phase;
        if (vld) begin
            last_exp = model(d, ov, ph);
            exp_q.push_back(last_exp);
            tag_q.push_back(tag);
        end
        m_phase    = cfg_tp_en ? (vld ? ~ph : ph) : 1'b0;
        m_prev_en  = cfg_tp_en;
        m_prev_sel = cfg_tp_sel;
        @(negedge clk);
    endtask

    // Monitor: compares each strobed result a quarter period after its edge.
    initial begin
        forever begin
            @(posedge clk);
            if (smp_vld && rst_n) begin
                #(CLK_P/4);
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2: actual %h expected none (queue empty)", out_word);
                end else begin
                    check(out_word, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({out_word_oe, clkout_oe, out_word[0]}, 3'b000, "R1 enables");
        check(out_word, '0, "R1 word");
        rst_n = 1'b1;
        step(0, '0, 0, "R11");
        check({out_word_oe, clkout_oe}, 2'b11, "R11 enabled");

        step(1, 14'h1234, 0, "R3 offset binary");
        step(1, 14'h3FFF, 1, "R3 ovf pass");
        cfg_twos = 1;
        step(1, 14'h2000, 0, "R3 twos msb");
        step(1, 14'h0001, 1, "R3 twos low");
        cfg_twos = 0; cfg_rand = 1;
        step(1, 14'h0ABD, 0, "R4 rand d0=1");
        step(1, 14'h0ABC, 1, "R4 rand d0=0");
        cfg_rand = 0; cfg_altpol = 1;
        step(1, 14'h0000, 1, "R5 altpol zero");
        step(1, 14'h3FFF, 0, "R5 altpol ones");
        cfg_rand = 1; cfg_twos = 1;
        step(1, 14'h1005, 0, "R6 combined");
        step(1, 14'h3333, 1, "R6 combined 2");

        step(0, 14'h0F0F, 0, "R2 hold");
        step(0, 14'h1111, 1, "R2 hold");
        check(out_word, last_exp, "R2 hold");

        cfg_tp_en = 1; cfg_tp_sel = 2'd0;
        step(1, 14'h1234, 0, "R7 ones");
        cfg_tp_sel = 2'd1;
        step(1, 14'h3FFF, 1, "R7 zeros");
        cfg_tp_sel = 2'd2;
        step(1, 14'h0, 0, "R8 alt first");
        step(1, 14'h0, 0, "R8 alt second");
        step(0, 14'h0, 0, "R8 idle");
        step(1, 14'h0, 0, "R8 alt third");
        step(1, 14'h0, 0, "R8 alt fourth");
        cfg_tp_sel = 2'd3;
        step(1, 14'h0, 0, "R9 checker first");
        step(1, 14'h0, 0, "R9 checker second");
        step(1, 14'h0, 0, "R9 checker third");
        cfg_tp_sel = 2'd2;
        step(0, 14'h0, 0, "R10 sel change");
        step(1, 14'h0, 0, "R10 restart on sel");
        step(1, 14'h0, 0, "R10 after restart");
        cfg_tp_en = 0;
        step(1, 14'h0155, 0, "R10 patterns off");
        cfg_tp_en = 1;
        step(1, 14'h0, 0, "R10 restart on enable");

        cfg_out_dis = 1;
        step(0, 14'h0, 0, "R11");
        check({out_word_oe, clkout_oe}, 2'b00, "R11 disabled");
        cfg_out_dis = 0;
        step(0, 14'h0, 0, "R11");
        check({out_word_oe, clkout_oe}, 2'b11, "R11 re-enabled");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule